// File: doc/BRIEF.md
# Serial-Configured Clock Output Enable Controller

This block fans one incoming clock out to thirteen outputs and lets a host on a two-wire serial bus switch each output on or off. The host writes a fixed ten-byte frame: an address byte, two header bytes whose values do not matter, and seven data bytes. Only the first three data bytes carry enable bits. Each of these bits is scattered to one output, and the remaining positions are reserved. A disabled output is held low. An enabled output is a running copy of the input clock.

The serial lines are oversampled by a system clock. The slave pulls the data line low to acknowledge each byte of a frame whose address matched. Enable bits are committed as each data byte completes. They are then carried into the buffer clock domain and applied only while that clock is low, so an output never emits a shortened pulse.

Top module: `clk_enable_ctrl`

## Requirements
- R1: The address byte is compared with 8'b11010010; on a match the slave pulls the data line low during the ninth serial clock of the address byte and of each later byte up to the tenth. On a mismatch it gives no acknowledge and ignores the rest of the frame until the next start condition.
- R2: Frame order is address, command byte, count byte, data byte 0 to data byte 6; the command and count values have no effect on the outputs.
- R3: Each byte is received most significant bit first (bit 7 first).
- R4: Data byte 0 sets outputs 0..3 from bits 0..3 and outputs 4 and 5 from bits 6 and 7; bits 4 and 5 are reserved and have no effect.
- R5: Data byte 1 sets outputs 6 and 7 from bits 0 and 1 and outputs 8..11 from bits 4..7; bits 2 and 3 are reserved and have no effect.
- R6: Data byte 2 bit 6 sets output 12; all its other bits are reserved and have no effect.
- R7: Data bytes 3 to 6 have no effect on the outputs, and a byte after the tenth is neither acknowledged nor used.
- R8: An enable bit of 1 makes the output a running copy of the input clock; 0 holds the output low.
- R9: After reset every output is enabled.
- R10: A stop or repeated start before the frame ends commits the data bytes fully received and drops a partly received byte.
- R11: An enable change reaches an output only while the input clock is low; an output is never high while the input clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls the open-drain data line low (acknowledge) |
| buf_clk_i | input | 1 | Clock to be fanned out |
| clk_out_o | output | 13 | Gated clock outputs, bit i is output i |

## Verification
The bench builds the block with its default parameters: the fixed address, two-stage input synchronizers and a two-stage enable synchronizer, with the serial bit time about sixteen system clocks and the buffer clock unrelated to the system clock. With thirteen outputs a sweep of every one-hot and every one-cold enable mask is short, and so is checking each output both in the high and in the low phase of the buffer clock. Further frames set every reserved bit, drive the ignored header and trailing bytes with opposite values, use wrong addresses, cut a frame partway through a data byte, and add an eleventh byte.

// File: rtl/clk_enable_pkg.sv
package clk_enable_pkg;
    localparam int OUT_COUNT  = 13;
    localparam int FRAME_LEN  = 10;
    localparam logic [3:0] DATA_FIRST = 4'd3;

    // Which data byte (0..2) drives output i
    function automatic logic [3:0] src_byte(input int i);
        if (i < 6)       return 4'd0;
        else if (i < 12) return 4'd1;
        else             return 4'd2;
    endfunction

    // Which bit of that byte drives output i
    function automatic logic [2:0] src_bit(input int i);
        if (i < 4)       return 3'(i);
        else if (i < 6)  return 3'(i + 2);
        else if (i < 8)  return 3'(i - 6);
        else if (i < 12) return 3'(i - 4);
        else             return 3'd6;
    endfunction
endpackage

// File: rtl/serial_front.sv
module serial_front #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic scl_lvl_o,
    output logic sda_lvl_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sync;
        logic [STAGES-1:0] sda_sync;
        logic              scl_prev;
        logic              sda_prev;
    } front_t;

    front_t q, d;

    logic scl_now, sda_now;
    assign scl_now = q.scl_sync[STAGES-1];
    assign sda_now = q.sda_sync[STAGES-1];

    always_comb begin
        d          = q;
        d.scl_sync = {q.scl_sync[STAGES-2:0], scl_i};
        d.sda_sync = {q.sda_sync[STAGES-2:0], sda_i};
        d.scl_prev = scl_now;
        d.sda_prev = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_rise_o = scl_now && !q.scl_prev;
    assign scl_fall_o = !scl_now && q.scl_prev;
    assign start_o    = scl_now && q.scl_prev && !sda_now && q.sda_prev;
    assign stop_o     = scl_now && q.scl_prev && sda_now && !q.sda_prev;
    assign scl_lvl_o  = scl_now;
    assign sda_lvl_o  = sda_now;
endmodule

// File: rtl/frame_engine.sv
module frame_engine
    import clk_enable_pkg::*;
#(
    parameter logic [7:0] SLAVE_ADDR = 8'b1101_0010
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_rise_i,
    input  logic                 scl_fall_i,
    input  logic                 start_i,
    input  logic                 stop_i,
    input  logic                 scl_lvl_i,
    input  logic                 sda_lvl_i,
    output logic                 sda_oe_o,
    output logic [OUT_COUNT-1:0] en_o
);
    localparam logic [3:0] LAST_IDX = 4'(FRAME_LEN);

    typedef struct packed {
        logic [7:0]           shreg;
        logic [3:0]           bit_cnt;
        logic [3:0]           byte_idx;
        logic                 in_ack;
        logic                 active;
        logic                 matched;
        logic                 oe;
        logic [OUT_COUNT-1:0] en;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d = q;
        if (start_i) begin
            d.active   = 1'b1;
            d.matched  = 1'b0;
            d.bit_cnt  = '0;
            d.byte_idx = '0;
            d.in_ack   = 1'b0;
            d.oe       = 1'b0;
        end else if (stop_i) begin
            d.active = 1'b0;
            d.in_ack = 1'b0;
            d.oe     = 1'b0;
        end else if (q.active) begin
            if (scl_rise_i && !q.in_ack && q.bit_cnt < 4'd8) begin
                d.shreg   = {q.shreg[6:0], sda_lvl_i};   // bit 7 arrives first
                d.bit_cnt = q.bit_cnt + 4'd1;
            end
            if (scl_fall_i) begin
                if (q.in_ack) begin
                    d.in_ack  = 1'b0;
                    d.oe      = 1'b0;
                    d.bit_cnt = '0;
                    if (q.byte_idx < LAST_IDX) d.byte_idx = q.byte_idx + 4'd1;
                    if (!q.matched) d.active = 1'b0;
                end else if (q.bit_cnt == 4'd8) begin
                    d.in_ack = 1'b1;
                    if (q.byte_idx == 4'd0) begin
                        d.matched = (q.shreg == SLAVE_ADDR);
                        d.oe      = (q.shreg == SLAVE_ADDR);
                    end else if (q.matched && q.byte_idx < LAST_IDX) begin
                        d.oe = 1'b1;
                        for (int i = 0; i < OUT_COUNT; i++) begin
                            if (src_byte(i) + DATA_FIRST == q.byte_idx)
                                d.en[i] = q.shreg[src_bit(i)];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.en       <= '1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign en_o     = q.en;

    assert_ack_needs_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> q.matched);
    assert_write_needs_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.en) |-> $past(q.matched));
    assert_ack_while_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_lvl_i);
    assert_byte_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.byte_idx <= LAST_IDX);
endmodule

// File: rtl/gate_bank.sv
module gate_bank #(
    parameter int N      = 13,
    parameter int STAGES = 2
) (
    input  logic         buf_clk_i,
    input  logic         rst_n,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] clk_out_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] sync;
    } gsync_t;

    gsync_t q, d;
    logic [N-1:0] gate_q;

    always_comb begin
        d      = q;
        d.sync = {q.sync[STAGES-2:0], en_i};
    end

    always_ff @(posedge buf_clk_i or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    // Gate enables move on the falling edge, so they change only while the clock is low
    for (genvar g = 0; g < N; g++) begin : g_gate
        always_ff @(negedge buf_clk_i or negedge rst_n) begin
            if (!rst_n) gate_q[g] <= 1'b1;
            else        gate_q[g] <= q.sync[STAGES-1][g];
        end
        assign clk_out_o[g] = buf_clk_i & gate_q[g];
    end
endmodule

// File: rtl/clk_enable_ctrl.sv
module clk_enable_ctrl
    import clk_enable_pkg::*;
#(
    parameter logic [7:0] SLAVE_ADDR  = 8'b1101_0010,
    parameter int         IN_STAGES   = 2,
    parameter int         GATE_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe_o,
    input  logic                 buf_clk_i,
    output logic [OUT_COUNT-1:0] clk_out_o
);
    logic scl_rise, scl_fall, start, stop, scl_lvl, sda_lvl;
    logic [OUT_COUNT-1:0] en;

    serial_front #(.STAGES(IN_STAGES)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start),
        .stop_o     (stop),
        .scl_lvl_o  (scl_lvl),
        .sda_lvl_o  (sda_lvl)
    );

    frame_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start),
        .stop_i     (stop),
        .scl_lvl_i  (scl_lvl),
        .sda_lvl_i  (sda_lvl),
        .sda_oe_o   (sda_oe_o),
        .en_o       (en)
    );

    gate_bank #(.N(OUT_COUNT), .STAGES(GATE_STAGES)) u_gates (
        .buf_clk_i (buf_clk_i),
        .rst_n     (rst_n),
        .en_i      (en),
        .clk_out_o (clk_out_o)
    );
endmodule

// File: tb/clk_enable_ctrl_tb.sv
`timescale 1ns/1ps
module clk_enable_ctrl_tb;
    localparam int T = 40;

    logic clk = 0, buf_clk = 0, rst_n = 0;
    logic scl = 1, m_low = 0;
    logic sda_oe;
    logic sda;
    logic [12:0] clk_out;
    logic [12:0] exp_mask;
    int errors = 0, checks = 0;
    logic done = 0;

    assign sda = ~(m_low | sda_oe);

    always #2.5 clk = ~clk;
    always #7 buf_clk = ~buf_clk;

    clk_enable_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .sda_oe_o(sda_oe), .buf_clk_i(buf_clk), .clk_out_o(clk_out)
    );

    task automatic chk(input logic [12:0] act, input logic [12:0] expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic chk_outs(input string tag);
        repeat (6) @(posedge buf_clk);
        #2;
        chk(clk_out, exp_mask, {tag, " high phase"});
        @(negedge buf_clk);
        #2;
        chk(clk_out, 13'h0, {tag, " low phase R11"});
    endtask

    task automatic start_cond();
        m_low = 0; #T; scl = 1; #T; m_low = 1; #T; scl = 0; #T;
    endtask

    task automatic stop_cond();
        m_low = 1; #T; scl = 1; #T; m_low = 0; #T;
    endtask

    task automatic send_bit(input logic b);
        m_low = !b; #T; scl = 1; #T; scl = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_low = 0; #T; scl = 1; #(T/2); ack = !sda; #(T/2); scl = 0; #T;
    endtask

    function automatic logic [7:0] byte0(input logic [12:0] m);
        return {m[5], m[4], 2'b00, m[3:0]};
    endfunction
    function automatic logic [7:0] byte1(input logic [12:0] m);
        return {m[11:8], 2'b00, m[7:6]};
    endfunction
    function automatic logic [7:0] byte2(input logic [12:0] m);
        return {1'b0, m[12], 6'b0};
    endfunction

    // Full frame; returns how many bytes were acknowledged
    task automatic frame(input logic [7:0] addr, input logic [7:0] hdr,
                         input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input logic [7:0] tail,
                         output int acks);
        logic a;
        logic [7:0] seq [10];
        seq = '{addr, hdr, ~hdr, d0, d1, d2, tail, ~tail, tail, ~tail};
        acks = 0;
        start_cond();
        for (int k = 0; k < 10; k++) begin
            send_byte(seq[k], a);
            if (a) acks++;
        end
        stop_cond();
    endtask

    task automatic write_mask(input logic [12:0] m, input logic [7:0] tail, output int acks);
        frame(8'hD2, 8'h5A, byte0(m), byte1(m), byte2(m), tail, acks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int acks;
        logic a;
        repeat (5) @(posedge clk);
        rst_n = 1;
        #1;
        chk({12'h0, sda_oe}, 13'h0, "R1 no ack after reset");
        exp_mask = '1;
        chk_outs("R9 reset all enabled");

        // R3 R4 R5 R6 R8: walk a single enabled output
        for (int i = 0; i < 13; i++) begin
            exp_mask = 13'(1) << i;
            write_mask(exp_mask, 8'(i * 17), acks);
            chk(13'(acks), 13'd10, "R1 R2 all ten bytes acked");
            chk_outs($sformatf("R3 R4 R5 R6 R8 one-hot %0d", i));
        end
        // walk a single disabled output
        for (int i = 0; i < 13; i++) begin
            exp_mask = ~(13'(1) << i);
            write_mask(exp_mask, 8'(255 - i), acks);
            chk_outs($sformatf("R3 R4 R5 R6 R8 one-cold %0d", i));
        end

        // Reserved bits set, header and tail opposite: no effect (R4 R5 R6 R7 R2)
        exp_mask = 13'h0A5A;
        frame(8'hD2, 8'hFF, byte0(exp_mask) | 8'h30, byte1(exp_mask) | 8'h0C,
              byte2(exp_mask) | 8'hBF, 8'hFF, acks);
        chk_outs("R4 R5 R6 R7 reserved and tail ignored");
        frame(8'hD2, 8'h00, byte0(exp_mask), byte1(exp_mask), byte2(exp_mask), 8'h00, acks);
        chk_outs("R2 R7 header values ignored");

        // Wrong address and read-direction address: nothing changes, no ack (R1)
        frame(8'hD0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, acks);
        chk(13'(acks), 13'd0, "R1 mismatch no ack");
        chk_outs("R1 mismatch leaves outputs");
        frame(8'hD3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, acks);
        chk(13'(acks), 13'd0, "R1 read address no ack");
        chk_outs("R1 read address leaves outputs");

        // Partial frame (R10): data0 full, data1 half, then stop
        exp_mask = '1;
        write_mask(exp_mask, 8'h00, acks);
        chk_outs("R10 preset all on");
        start_cond();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'h00, a);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        scl = 0;
        stop_cond();
        exp_mask = 13'h1FC0;
        chk_outs("R10 partial frame commits byte0 only");

        // Repeated start mid-frame (R10): data0,data1 full, then new frame with bad address
        exp_mask = '1;
        start_cond();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'hFF, a); send_byte(8'hFF, a);
        start_cond();
        send_byte(8'h10, a);
        chk({12'h0, a}, 13'h0, "R1 mismatch after repeated start");
        stop_cond();
        chk_outs("R10 repeated start keeps full bytes");

        // Eleventh byte: not acked, not used (R7)
        exp_mask = 13'h0003;
        start_cond();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(byte0(exp_mask), a); send_byte(byte1(exp_mask), a);
        send_byte(byte2(exp_mask), a);
        for (int k = 0; k < 4; k++) send_byte(8'hFF, a);
        chk({12'h0, a}, 13'h1, "R1 tenth byte acked");
        send_byte(8'hFF, a);
        chk({12'h0, a}, 13'h0, "R7 eleventh byte not acked");
        stop_cond();
        chk_outs("R7 eleventh byte ignored");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule